// File: doc/BRIEF.md
# Pixel Switch and FIFO Write Sequencer

This block sits between the backplane timing lines and an eight-channel analog video chain. A four-bit pixel control word is latched whenever its strobe is high on a clock edge. Each latched word is decoded into three kinds of output: integrator reset, an integrate command, and an A/D conversion start. The integrate command is steered to one of two active-low resistor-path enables by a stored gain bit. A separate configuration write loads that gain bit.

When bit 3 of the latched word rises, the block runs an automatic burst that unloads the converters. The burst visits the eight converters in a fixed order. For each one it first enables that converter's active-low read line. One clock later it drops the shared FIFO write line for one clock. A busy flag covers the whole burst, and a new burst request that arrives while busy is high is dropped. One pixel period is driven by a repeating loop of seven control words. That loop is expected to give exactly one conversion start and one burst per pass.

Top module: `pix_seq`

## Requirements
- R1: After rst_ni is released, and before any strobe, the outputs are idle. Both integrate lines are high, int_rst_o is 0, adc_start_o is 0, all adc_rd_no bits are 1, fifo_wr_no is 1 and busy_o is 0. The latched word resets to 4'b1111 and the gain bit resets to 0.
- R2: ctl_i is captured only on a clock edge where ctl_stb_i is 1. Changes on ctl_i without the strobe have no effect on any output.
- R3: The integrate lines follow latched bit 0. While it is 0, int_slow_no is low when the gain bit is 1, and int_fast_no is low when the gain bit is 0. While it is 1, both lines are high. Both lines are never low together.
- R4: The gain bit takes cfg_d0_i on each edge where cfg_wr_i is 1, and keeps its value otherwise.
- R5: int_rst_o is 1 exactly while latched bit 1 is 0. It changes in the cycle after the strobe edge.
- R6: A strobe edge that latches bit 2 as 0, when the previously latched bit 2 was 1, makes adc_start_o 1 for exactly the next cycle. No other strobe edge does this.
- R7: A strobe edge that latches bit 3 as 1, when the previous bit 3 was 0 and busy_o is 0, starts a 16-cycle burst in the following cycle. In burst cycles 2k+1 and 2k+2 (k = 0..7), adc_rd_no[k] alone is low. Bit 0 is channel A and bit 7 is channel H. fifo_wr_no is low only in cycle 2k+2.
- R8: busy_o is 1 exactly during the 16 burst cycles. A bit-3 rising edge latched while busy_o is 1 starts no burst and does not extend the current one.
- R9: Outside a burst, all adc_rd_no bits and fifo_wr_no are 1.
- R10: Take a latched word of 4'b0111, then strobe the loop 0110, 0111, 0011, 0111, 1111, 0101, 0111 with each burst allowed to finish. Each pass of the loop then yields exactly one conversion start and exactly one burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_i | input | 4 | Pixel control word |
| ctl_stb_i | input | 1 | Latch strobe for ctl_i |
| cfg_wr_i | input | 1 | Write strobe for the gain bit |
| cfg_d0_i | input | 1 | Gain bit value: 1 slow/low gain, 0 fast/high gain |
| int_slow_no | output | 1 | Integrate enable, slow path, active low |
| int_fast_no | output | 1 | Integrate enable, fast path, active low |
| int_rst_o | output | 1 | Integrator reset, active high |
| adc_start_o | output | 1 | One-cycle conversion start pulse |
| adc_rd_no | output | 8 | Per-converter read enables, active low, bit 0 = A |
| fifo_wr_no | output | 1 | FIFO write strobe, active low |
| busy_o | output | 1 | Burst in progress |

## Verification
A corrupted burst counter or phase shows up within one cycle at the ports. It appears as a wrong read line low, a write pulse without its setup cycle, or busy_o dropping before 16 cycles have passed. A stale or wrongly updated control latch appears in the cycle after the strobe, through int_rst_o and the integrate lines. Missed or extra edge detections surface as a missing or extra adc_start_o pulse or burst. The pixel-loop count checks catch these. A lost gain bit flips which integrate line is low the next time bit 0 is 0.

// File: rtl/pix_seq_pkg.sv
`timescale 1ns/1ps
package pix_seq_pkg;
  localparam int unsigned CTL_W = 4;
  typedef enum logic {
    PH_SETUP  = 1'b0,
    PH_STROBE = 1'b1
  } burst_ph_e;
endpackage

// File: rtl/pix_ctl_latch.sv
`timescale 1ns/1ps
module pix_ctl_latch
  import pix_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             ctl_stb_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_d0_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             gain_o,
  output logic             conv_start_o,
  output logic             burst_req_o
);
  logic [CTL_W-1:0] ctl_q;
  logic             gain_q;
  logic             start_q;
  logic             fall2;

  assign fall2       = ctl_stb_i & ctl_q[2] & ~ctl_i[2];
  assign burst_req_o = ctl_stb_i & ~ctl_q[3] & ctl_i[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '1;
      gain_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= fall2;
      if (ctl_stb_i) ctl_q  <= ctl_i;
      if (cfg_wr_i)  gain_q <= cfg_d0_i;
    end
  end

  assign ctl_o        = ctl_q;
  assign gain_o       = gain_q;
  assign conv_start_o = start_q;
endmodule

// File: rtl/pix_int_decode.sv
`timescale 1ns/1ps
module pix_int_decode
  import pix_seq_pkg::*;
(
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             gain_i,
  output logic             int_slow_no,
  output logic             int_fast_no,
  output logic             int_rst_o
);
  logic integ;

  always_comb begin
    integ       = ~ctl_i[0];
    int_slow_no = ~(integ &  gain_i);
    int_fast_no = ~(integ & ~gain_i);
    int_rst_o   = ~ctl_i[1];
  end
endmodule

// File: rtl/pix_fifo_burst.sv
`timescale 1ns/1ps
module pix_fifo_burst
  import pix_seq_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  output logic [NCH-1:0] rd_no,
  output logic           wr_no,
  output logic           busy_o
);
  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [CH_W-1:0] CH_LAST = CH_W'(NCH - 1);

  logic            busy_q;
  burst_ph_e       ph_q;
  logic [CH_W-1:0] ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= PH_SETUP;
      ch_q   <= '0;
    end else if (!busy_q) begin
      if (req_i) begin
        busy_q <= 1'b1;
        ph_q   <= PH_SETUP;
        ch_q   <= '0;
      end
    end else if (ph_q == PH_SETUP) begin
      ph_q <= PH_STROBE;
    end else begin
      ph_q <= PH_SETUP;
      if (ch_q == CH_LAST) begin
        busy_q <= 1'b0;
        ch_q   <= '0;
      end else begin
        ch_q <= ch_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_rd
    assign rd_no[g] = ~(busy_q && (ch_q == CH_W'(g)));
  end

  assign wr_no  = ~(busy_q && (ph_q == PH_STROBE));
  assign busy_o = busy_q;
endmodule

// File: rtl/pix_seq.sv
`timescale 1ns/1ps
module pix_seq
  import pix_seq_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [3:0]     ctl_i,
  input  logic           ctl_stb_i,
  input  logic           cfg_wr_i,
  input  logic           cfg_d0_i,
  output logic           int_slow_no,
  output logic           int_fast_no,
  output logic           int_rst_o,
  output logic           adc_start_o,
  output logic [NCH-1:0] adc_rd_no,
  output logic           fifo_wr_no,
  output logic           busy_o
);
  logic [CTL_W-1:0] ctl_q;
  logic             gain_q;
  logic             burst_req;

  pix_ctl_latch u_latch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctl_i        (ctl_i),
    .ctl_stb_i    (ctl_stb_i),
    .cfg_wr_i     (cfg_wr_i),
    .cfg_d0_i     (cfg_d0_i),
    .ctl_o        (ctl_q),
    .gain_o       (gain_q),
    .conv_start_o (adc_start_o),
    .burst_req_o  (burst_req)
  );

  pix_int_decode u_dec (
    .ctl_i       (ctl_q),
    .gain_i      (gain_q),
    .int_slow_no (int_slow_no),
    .int_fast_no (int_fast_no),
    .int_rst_o   (int_rst_o)
  );

  pix_fifo_burst #(.NCH(NCH)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (burst_req),
    .rd_no  (adc_rd_no),
    .wr_no  (fifo_wr_no),
    .busy_o (busy_o)
  );
endmodule

// File: rtl/pix_seq_chk.sv
`timescale 1ns/1ps
module pix_seq_chk #(
  parameter int unsigned NCH = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           int_slow_no,
  input logic           int_fast_no,
  input logic           adc_start_o,
  input logic [NCH-1:0] adc_rd_no,
  input logic           fifo_wr_no,
  input logic           busy_o
);
  a_r3_int_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_slow_no || int_fast_no));

  a_r7_wr_one_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_wr_no |-> $countones(~adc_rd_no) == 1);

  a_r7_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_wr_no |=> fifo_wr_no);

  a_r7_rd_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fifo_wr_no) |-> $stable(adc_rd_no));

  a_r7_rd_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~adc_rd_no));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (&adc_rd_no) && fifo_wr_no);

  a_r6_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);
endmodule

bind pix_seq pix_seq_chk #(.NCH(NCH)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .int_slow_no (int_slow_no),
  .int_fast_no (int_fast_no),
  .adc_start_o (adc_start_o),
  .adc_rd_no   (adc_rd_no),
  .fifo_wr_no  (fifo_wr_no),
  .busy_o      (busy_o)
);

// File: tb/pix_seq_tb_top.sv
`timescale 1ns/1ps
module pix_seq_tb_top;
  localparam int NCH = 8;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [3:0]     ctl_i = 4'hF;
  logic           ctl_stb_i = 1'b0;
  logic           cfg_wr_i = 1'b0;
  logic           cfg_d0_i = 1'b0;
  logic           int_slow_no, int_fast_no, int_rst_o, adc_start_o;
  logic [NCH-1:0] adc_rd_no;
  logic           fifo_wr_no, busy_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pix_seq #(.NCH(NCH)) dut_i (.*);

  // reference model built from the requirements
  logic [3:0] m_ctl;
  logic       m_gain;
  logic       m_start;
  int         m_bcnt;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctl <= 4'hF; m_gain <= 1'b0; m_start <= 1'b0; m_bcnt <= 0;
    end else begin
      m_start <= ctl_stb_i && m_ctl[2] && !ctl_i[2];
      if (m_bcnt != 0) m_bcnt <= (m_bcnt == 2*NCH) ? 0 : m_bcnt + 1;
      else if (ctl_stb_i && !m_ctl[3] && ctl_i[3]) m_bcnt <= 1;
      if (ctl_stb_i) m_ctl <= ctl_i;
      if (cfg_wr_i) m_gain <= cfg_d0_i;
    end
  end

  function automatic logic [NCH-1:0] exp_rd(int bcnt);
    logic [NCH-1:0] v = '1;
    if (bcnt != 0) v[(bcnt-1)/2] = 1'b0;
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  int  obs_starts = 0;
  int  obs_bursts = 0;
  bit  prev_busy  = 1'b0;
  bit  mon_en     = 1'b0;

  always @(negedge clk_i) begin
    if (mon_en && rst_ni) begin
      check(int_slow_no == !(!m_ctl[0] && m_gain), "R3 slow", int_slow_no, !(!m_ctl[0] && m_gain));
      check(int_fast_no == !(!m_ctl[0] && !m_gain), "R3 fast", int_fast_no, !(!m_ctl[0] && !m_gain));
      check(int_rst_o == !m_ctl[1], "R5 int_rst", int_rst_o, !m_ctl[1]);
      check(adc_start_o == m_start, "R6 start", adc_start_o, m_start);
      check(busy_o == (m_bcnt != 0), "R8 busy", busy_o, m_bcnt != 0);
      if (m_bcnt != 0) begin
        check(adc_rd_no == exp_rd(m_bcnt), "R7 rd", adc_rd_no, exp_rd(m_bcnt));
        check(fifo_wr_no == (m_bcnt % 2 == 1), "R7 wr", fifo_wr_no, m_bcnt % 2 == 1);
      end else begin
        check(&adc_rd_no && fifo_wr_no, "R9 idle", {adc_rd_no, fifo_wr_no}, {NCH+1{1'b1}});
      end
    end
    if (adc_start_o) obs_starts++;
    if (busy_o && !prev_busy) obs_bursts++;
    prev_busy = busy_o;
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      ctl_stb_i = 1'b0; cfg_wr_i = 1'b0;
    end
  endtask

  task automatic strobe(logic [3:0] w);
    @(negedge clk_i);
    ctl_i = w; ctl_stb_i = 1'b1; cfg_wr_i = 1'b0;
    @(negedge clk_i);
    ctl_stb_i = 1'b0;
  endtask

  task automatic set_gain(logic g);
    @(negedge clk_i);
    cfg_d0_i = g; cfg_wr_i = 1'b1;
    @(negedge clk_i);
    cfg_wr_i = 1'b0; cfg_d0_i = ~g;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int b0, s0;
    logic [3:0] loop_w [7] = '{4'b0110, 4'b0111, 4'b0011, 4'b0111, 4'b1111, 4'b0101, 4'b0111};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(int_slow_no && int_fast_no && !int_rst_o && !adc_start_o, "R1 ctl outs",
          {int_slow_no, int_fast_no, int_rst_o, adc_start_o}, 4'b1100);
    check(&adc_rd_no && fifo_wr_no && !busy_o, "R1 burst outs",
          {adc_rd_no, fifo_wr_no, busy_o}, {{NCH+1{1'b1}}, 1'b0});
    mon_en = 1'b1;

    // R4 gain reset 0 -> fast path on integrate
    strobe(4'b0110);
    check(int_fast_no == 1'b0 && int_slow_no == 1'b1, "R4 reset gain fast", {int_slow_no, int_fast_no}, 2'b10);
    set_gain(1'b1);
    idle(1);
    check(int_slow_no == 1'b0 && int_fast_no == 1'b1, "R4 gain slow", {int_slow_no, int_fast_no}, 2'b01);
    set_gain(1'b0);

    // R2 no strobe -> no effect
    strobe(4'b0111);
    @(negedge clk_i); ctl_i = 4'b1000;
    idle(5);
    check(!int_rst_o && int_slow_no && int_fast_no && !busy_o, "R2 ignore unstrobed",
          {int_rst_o, int_slow_no, int_fast_no, busy_o}, 4'b0110);

    // R10 pixel loop, two passes
    strobe(4'b0111); idle(20);
    s0 = obs_starts; b0 = obs_bursts;
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 7; k++) begin strobe(loop_w[k]); idle(20); end
    check(obs_starts - s0 == 2, "R10 starts", obs_starts - s0, 2);
    check(obs_bursts - b0 == 2, "R10 bursts", obs_bursts - b0, 2);

    // R8 second rise during burst ignored
    strobe(4'b0111);
    b0 = obs_bursts;
    strobe(4'b1111);
    strobe(4'b0111);
    strobe(4'b1111);
    idle(40);
    check(obs_bursts - b0 == 1, "R8 ignored rise", obs_bursts - b0, 1);

    // R6 back-to-back falls on bit 2
    s0 = obs_starts;
    strobe(4'b0011); strobe(4'b0111); strobe(4'b0011);
    idle(3);
    check(obs_starts - s0 == 2, "R6 two starts", obs_starts - s0, 2);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i);
      ctl_stb_i = ($urandom % 3) == 0;
      ctl_i     = 4'($urandom);
      cfg_wr_i  = ($urandom % 16) == 0;
      cfg_d0_i  = 1'($urandom);
    end
    idle(40);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule